// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds two timer channels that share one free-running up-counter. The counter runs from zero to a programmable modulo value and then wraps. Each channel owns one pin and has its own 4-bit control word and 16-bit value register. The control word sets what the channel does. It can leave the pin to general-purpose I/O while holding a preset level ready. It can latch the counter on a selected edge of the pin (input capture). It can also set, clear or toggle the pin when the counter equals the value register (output compare, or PWM when the overflow restores the level).

Channel 0 has one more mode, the buffered mode, which takes over channel 1. In this mode channel 1 gives up its pin, and the two value registers alternate as channel 0's compare value. A newly written value takes effect only at the next counter overflow, so a PWM period is never cut short. The mode bits may only be changed while the counter is both stopped and held clear. Each channel has an event flag that stays set until software writes a 1 to it.

Control word layout (bit 3 = buffered mode B, bit 2 = mode A, bits 1:0 = edge/level field). Write addresses: 0 = channel 0 control, 1 = channel 1 control, 2 = channel 0 value, 3 = channel 1 value, 4 = flag clear (bit n clears the flag of channel n).

Top module: `tcp_pair`

## Requirements
- R1: During and after reset, all control bits are 0, both value registers, the counter and both flags are 0, both pins are not owned by the timer, and both pin outputs are 1.
- R2: With edge/level field 00, the channel does not own its pin (pin_own low one cycle later). Its pin output takes the preset level: 0 when mode A is 1, and 1 when mode A is 0.
- R3: Writes to mode bits A and B take effect only while tmr_stop and tmr_clear are both high, and are ignored otherwise. The edge/level field is written at any time.
- R4: With a nonzero edge/level field and B:A = 00, the pin passes through a two-flop synchroniser. Field 01 captures on rising edges, 10 on falling edges, and 11 on both. A capture loads the current count into the channel value register.
- R5: A capture or compare event sets the channel flag, which stays set until a write to address 4 with that channel's bit at 1. If a clear and a new event fall in the same cycle, the event wins.
- R6: tmr_clear forces the counter to 0. tmr_stop alone holds it. Otherwise it increments and wraps from cnt_mod to 0.
- R7: With mode A or B at 1 and a nonzero field, a running counter that equals the compare value toggles the pin (field 01), drives it to 0 (10) or drives it to 1 (11), and sets the flag.
- R8: At counter overflow, a compare channel with field 10 returns its pin to 1 and one with field 11 returns it to 0. When a compare match and an overflow fall in the same cycle, the compare action wins.
- R9: With channel 0 mode B at 1, channel 1 releases its pin and makes no events. Channel 0 compares against value register 0 first. After a write to either value register, the written register becomes the compare value at the next overflow.
- R10: Channel 1 has no mode B bit: writing bit 3 of its control word has no effect, so it still does input capture when A is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_stop | input | 1 | Holds the counter |
| tmr_clear | input | 1 | Forces the counter to 0 |
| cnt_mod | input | 16 | Last count before wrap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pin_in | input | 2 | Pin levels, one bit per channel |
| count | output | 16 | Current counter value |
| pin_out | output | 2 | Timer pin drive levels |
| pin_own | output | 2 | 1 = pin driven by timer, 0 = general-purpose I/O |
| evt_flag | output | 2 | Sticky capture/compare flags |
| val0 | output | 16 | Channel 0 value register |
| val1 | output | 16 | Channel 1 value register |

## Verification
Two functions can fall in the same cycle: a compare match and a counter overflow, when the compare value equals cnt_mod. The bench sets channel 1 to clear-on-compare with its value equal to the modulo. It then expects the pin to stay low across every wrap rather than being restored high. A second collision, a flag clear written in the cycle a capture lands, comes from pin toggles placed near clear writes. The behavioural model is expected to keep the flag set.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef struct packed {
    logic       mb;   // buffered mode (channel 0 only)
    logic       ma;   // unbuffered compare / preset level
    logic [1:0] els;  // edge/level field
  } chan_ctrl_t;

  localparam logic [1:0] ELS_OFF = 2'b00;
  localparam logic [1:0] ELS_TOG = 2'b01;
  localparam logic [1:0] ELS_CLR = 2'b10;
  localparam logic [1:0] ELS_SET = 2'b11;

  localparam logic [2:0] A_CTL0 = 3'd0;
  localparam logic [2:0] A_VAL0 = 3'd2;
  localparam logic [2:0] A_FCLR = 3'd4;
endpackage

// File: rtl/tcp_counter.sv
module tcp_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop,
  input  logic          clr,
  input  logic [CW-1:0] modv,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          ovf
);
  assign run = !stop && !clr;
  assign ovf = run && (cnt == modv);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (ovf)    cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop && !clr && cnt == modv) |=> (cnt == '0));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tcp_bufsel.sv
module tcp_bufsel (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr0,
  input  logic wr1,
  input  logic ovf,
  output logic sel
);
  logic pend, psel;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sel  <= 1'b0;
      pend <= 1'b0;
      psel <= 1'b0;
    end else begin
      if (ovf && pend) sel <= psel;
      if (wr0 || wr1) begin
        pend <= 1'b1;
        psel <= wr1;
      end else if (ovf) begin
        pend <= 1'b0;
      end
    end
  end

  // R9
  swap_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ovf && $past(en)) |=> $stable(sel));
endmodule

// File: rtl/tcp_channel.sv
module tcp_channel
  import tcp_pkg::*;
#(
  parameter int CW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  chan_ctrl_t    ctrl,
  input  logic          disabled,
  input  logic [CW-1:0] cnt,
  input  logic          run,
  input  logic          ovf,
  input  logic [CW-1:0] cmp_val,
  input  logic          pin_in,
  output logic          cap_evt,
  output logic          cmp_evt,
  output logic          pin_out,
  output logic          pin_own
);
  localparam int SL = SYNC_STAGES + 1;

  logic [SL-1:0] sh;
  logic rise, fall, cmp_mode, cap_mode, match;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SL-2:0], pin_in};
  end

  assign rise     = sh[SL-2] && !sh[SL-1];
  assign fall     = !sh[SL-2] && sh[SL-1];
  assign cmp_mode = ctrl.ma || ctrl.mb;
  assign cap_mode = !cmp_mode && (ctrl.els != ELS_OFF);
  assign match    = run && (cnt == cmp_val);
  assign cap_evt  = !disabled && cap_mode &&
                    ((ctrl.els[0] && rise) || (ctrl.els[1] && fall));
  assign cmp_evt  = !disabled && cmp_mode && (ctrl.els != ELS_OFF) && match;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b1;
      pin_own <= 1'b0;
    end else begin
      pin_own <= (ctrl.els != ELS_OFF) && !disabled;
      if (ctrl.els == ELS_OFF) begin
        pin_out <= !ctrl.ma;
      end else if (!disabled && cmp_mode) begin
        if (match) begin
          unique case (ctrl.els)
            ELS_TOG: pin_out <= !pin_out;
            ELS_CLR: pin_out <= 1'b0;
            default: pin_out <= 1'b1;
          endcase
        end else if (ovf && ctrl.els != ELS_TOG) begin
          pin_out <= (ctrl.els == ELS_CLR);
        end
      end
    end
  end

  // R2
  gpio_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.els == ELS_OFF) |=> !pin_own);
  // R8
  cmp_win_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_evt && ovf && ctrl.els == ELS_CLR) |=> !pin_out);
endmodule

// File: rtl/tcp_pair.sv
module tcp_pair
  import tcp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmr_stop,
  input  logic          tmr_clear,
  input  logic [CW-1:0] cnt_mod,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    pin_in,
  output logic [CW-1:0] count,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_own,
  output logic [1:0]    evt_flag,
  output logic [CW-1:0] val0,
  output logic [CW-1:0] val1
);
  localparam int NCH = 2;

  logic [CW-1:0] cnt;
  logic          run, ovf, bsel, unlocked;
  chan_ctrl_t    ctrl_q [NCH];
  logic [CW-1:0] val_q  [NCH];
  logic          flag_q [NCH];
  logic          cap_e  [NCH];
  logic          cmp_e  [NCH];
  logic          vwr    [NCH];

  assign unlocked = tmr_stop && tmr_clear;

  tcp_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .stop(tmr_stop), .clr(tmr_clear),
    .modv(cnt_mod), .cnt(cnt), .run(run), .ovf(ovf)
  );

  tcp_bufsel u_buf (
    .clk(clk), .rst(rst), .en(ctrl_q[0].mb), .wr0(vwr[0]), .wr1(vwr[1]),
    .ovf(ovf), .sel(bsel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] cmp_sel;
    logic          dis;
    logic          ctl_wr, clr_bit;

    assign ctl_wr  = wr_en && (wr_addr == A_CTL0 + 3'(g));
    assign vwr[g]  = wr_en && (wr_addr == A_VAL0 + 3'(g));
    assign clr_bit = wr_en && (wr_addr == A_FCLR) && wr_data[g];

    if (g == 0) begin : g_buf
      assign dis     = 1'b0;
      assign cmp_sel = (ctrl_q[0].mb && bsel) ? val_q[1] : val_q[0];
    end else begin : g_plain
      assign dis     = ctrl_q[0].mb;
      assign cmp_sel = val_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[g] <= '0;
      end else if (ctl_wr) begin
        ctrl_q[g].els <= wr_data[1:0];
        if (unlocked) begin
          ctrl_q[g].ma <= wr_data[2];
          ctrl_q[g].mb <= (g == 0) ? wr_data[3] : 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)         val_q[g] <= '0;
      else if (cap_e[g]) val_q[g] <= cnt;
      else if (vwr[g]) val_q[g] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[g] <= 1'b0;
      else     flag_q[g] <= (flag_q[g] && !clr_bit) || cap_e[g] || cmp_e[g];
    end

    tcp_channel #(.CW(CW), .SYNC_STAGES(2)) u_ch (
      .clk(clk), .rst(rst), .ctrl(ctrl_q[g]), .disabled(dis), .cnt(cnt),
      .run(run), .ovf(ovf), .cmp_val(cmp_sel), .pin_in(pin_in[g]),
      .cap_evt(cap_e[g]), .cmp_evt(cmp_e[g]),
      .pin_out(pin_out[g]), .pin_own(pin_own[g])
    );

    // R3
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
      !unlocked |=> $stable(ctrl_q[g].ma));
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_e[g] || cmp_e[g]) |=> evt_flag[g]);
  end

  // R9
  ch1_release_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[0].mb |=> !pin_own[1]);

  assign count    = cnt;
  assign evt_flag = {flag_q[1], flag_q[0]};
  assign val0     = val_q[0];
  assign val1     = val_q[1];
endmodule

// File: tb/sim_tcp_pair.sv
module sim_tcp_pair;
  logic        clk = 1'b0;
  logic        rst, tmr_stop, tmr_clear, wr_en;
  logic [15:0] cnt_mod, wr_data;
  logic [2:0]  wr_addr;
  logic [1:0]  pin_in;
  logic [15:0] count, val0, val1;
  logic [1:0]  pin_out, pin_own, evt_flag;

  int total = 0, bad = 0, cyc = 0;
  bit chk_on = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_ctl[2], m_val[2], m_flag[2], m_out[2], m_own[2];
  int m_s1[2], m_s2[2], m_s3[2], m_bsel, m_pend, m_psel;

  always #5 clk = ~clk;

  tcp_pair u0 (
    .clk(clk), .rst(rst), .tmr_stop(tmr_stop), .tmr_clear(tmr_clear),
    .cnt_mod(cnt_mod), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_in(pin_in), .count(count), .pin_out(pin_out), .pin_own(pin_own),
    .evt_flag(evt_flag), .val0(val0), .val1(val1)
  );

  always @(posedge clk) begin
    int n_cnt, n_ctl[2], n_val[2], n_flag[2], n_out[2], n_own[2];
    int run, ovf, ma, mb, els, dis, cmpv, rise, fall, cmpm, capm, hit, cap, cmpe, mb0, wrv;
    if (rst) begin
      m_cnt = 0; m_bsel = 0; m_pend = 0; m_psel = 0;
      for (int c = 0; c < 2; c++) begin
        m_ctl[c] = 0; m_val[c] = 0; m_flag[c] = 0; m_out[c] = 1; m_own[c] = 0;
        m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0;
      end
    end else begin
      run = (!tmr_stop && !tmr_clear) ? 1 : 0;
      ovf = (run == 1 && m_cnt == int'(cnt_mod)) ? 1 : 0;
      mb0 = (m_ctl[0] >> 3) & 1;
      for (int c = 0; c < 2; c++) begin
        ma = (m_ctl[c] >> 2) & 1; mb = (m_ctl[c] >> 3) & 1; els = m_ctl[c] & 3;
        dis = (c == 1) ? mb0 : 0;
        cmpv = (c == 0 && mb == 1) ? m_val[m_bsel] : m_val[c];
        rise = (m_s2[c] == 1 && m_s3[c] == 0) ? 1 : 0;
        fall = (m_s2[c] == 0 && m_s3[c] == 1) ? 1 : 0;
        cmpm = ma | mb;
        capm = (cmpm == 0 && els != 0) ? 1 : 0;
        hit  = (run == 1 && m_cnt == cmpv) ? 1 : 0;
        cap  = (dis == 0 && capm == 1 && ((els == 1 && rise == 1) || (els == 2 && fall == 1) ||
                (els == 3 && (rise | fall) == 1))) ? 1 : 0;
        cmpe = (dis == 0 && els != 0 && cmpm == 1 && hit == 1) ? 1 : 0;
        n_own[c] = (els != 0 && dis == 0) ? 1 : 0;
        n_out[c] = m_out[c];
        if (els == 0) n_out[c] = 1 - ma;
        else if (dis == 0 && cmpm == 1) begin
          if (hit == 1) n_out[c] = (els == 1) ? 1 - m_out[c] : (els == 2 ? 0 : 1);
          else if (ovf == 1 && els != 1) n_out[c] = (els == 2) ? 1 : 0;
        end
        wrv = (wr_en && int'(wr_addr) == 2 + c) ? 1 : 0;
        n_val[c] = (cap == 1) ? m_cnt : (wrv == 1 ? int'(wr_data) : m_val[c]);
        n_flag[c] = ((m_flag[c] == 1 && !(wr_en && wr_addr == 3'd4 && wr_data[c])) || cap == 1 || cmpe == 1) ? 1 : 0;
        n_ctl[c] = m_ctl[c];
        if (wr_en && int'(wr_addr) == c) begin
          n_ctl[c] = (n_ctl[c] & 12) | int'(wr_data[1:0]);
          if (tmr_stop && tmr_clear)
            n_ctl[c] = (n_ctl[c] & 3) | (int'(wr_data[2]) << 2) | ((c == 0) ? int'(wr_data[3]) << 3 : 0);
        end
      end
      if (mb0 == 0) begin
        m_bsel = 0; m_pend = 0; m_psel = 0;
      end else begin
        if (ovf == 1 && m_pend == 1) m_bsel = m_psel;
        if (wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3)) begin
          m_pend = 1; m_psel = (wr_addr == 3'd3) ? 1 : 0;
        end else if (ovf == 1) m_pend = 0;
      end
      if (tmr_clear) n_cnt = 0;
      else if (ovf == 1) n_cnt = 0;
      else if (run == 1) n_cnt = m_cnt + 1;
      else n_cnt = m_cnt;
      m_cnt = n_cnt;
      for (int c = 0; c < 2; c++) begin
        m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = int'(pin_in[c]);
        m_ctl[c] = n_ctl[c]; m_val[c] = n_val[c]; m_flag[c] = n_flag[c];
        m_out[c] = n_out[c]; m_own[c] = n_own[c];
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      chk(cur_req, "count", int'(count), m_cnt);
      chk(cur_req, "val0", int'(val0), m_val[0]);
      chk(cur_req, "val1", int'(val1), m_val[1]);
      chk(cur_req, "pin_out", int'(pin_out), m_out[1] * 2 + m_out[0]);
      chk(cur_req, "pin_own", int'(pin_own), m_own[1] * 2 + m_own[0]);
      chk(cur_req, "evt_flag", int'(evt_flag), m_flag[1] * 2 + m_flag[0]);
    end
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic halt(bit v);
    @(negedge clk);
    tmr_stop = v; tmr_clear = v;
  endtask

  initial begin
    rst = 1'b1; tmr_stop = 1'b0; tmr_clear = 1'b0; cnt_mod = 16'd20;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; pin_in = 2'b00;
    @(posedge clk);
    @(negedge clk);
    chk_on = 1;
    tick(2);
    rst = 1'b0;
    chk("R1", "pin_out after reset", int'(pin_out), 3);
    chk("R1", "pin_own after reset", int'(pin_own), 0);

    cur_req = "R2";
    halt(1);
    wr(0, 4'b0100);
    wr(1, 4'b0000);
    tick(2);
    chk("R2", "preset levels", int'(pin_out), 2'b10);
    chk("R2", "gpio ownership", int'(pin_own), 0);

    cur_req = "R3";
    halt(0);
    wr(0, 4'b0000);
    tick(2);
    chk("R3", "locked mode A write ignored", int'(pin_out[0]), 0);

    cur_req = "R6";
    tick(50);

    cur_req = "R4";
    halt(1);
    wr(0, 4'b0001);
    wr(1, 4'b0010);
    halt(0);
    tick(3);
    pin_in = 2'b01; tick(6);
    chk("R4", "rising capture flag", int'(evt_flag[0]), 1);
    pin_in = 2'b11; tick(5);
    pin_in = 2'b00; tick(9);
    pin_in = 2'b10; tick(4);
    pin_in = 2'b00; tick(7);
    wr(0, 4'b0011);
    pin_in = 2'b01; tick(5);
    pin_in = 2'b00; tick(6);

    cur_req = "R5";
    wr(4, 3);
    tick(1);
    chk("R5", "flags cleared", int'(evt_flag), 0);
    pin_in = 2'b01;
    tick(1);
    wr(4, 1);
    tick(4);
    pin_in = 2'b00;
    tick(1);
    wr(4, 1);
    tick(5);

    cur_req = "R7";
    halt(1);
    wr(0, 4'b0101);
    wr(1, 4'b0110);
    wr(2, 5);
    wr(3, 8);
    wr(4, 3);
    halt(0);
    tick(60);
    wr(1, 4'b0111);
    tick(45);

    cur_req = "R8";
    halt(1);
    wr(1, 4'b0110);
    wr(3, 20);
    halt(0);
    tick(50);
    chk("R8", "match beats overflow", int'(pin_out[1]), 0);

    cur_req = "R9";
    halt(1);
    wr(0, 4'b1010);
    wr(2, 6);
    wr(3, 12);
    halt(0);
    tick(30);
    chk("R9", "channel 1 released", int'(pin_own[1]), 0);
    wr(3, 15);
    tick(30);
    wr(2, 3);
    tick(45);

    cur_req = "R10";
    halt(1);
    wr(0, 4'b0000);
    wr(1, 4'b1001);
    wr(4, 3);
    halt(0);
    tick(3);
    pin_in = 2'b10;
    tick(5);
    chk("R10", "channel 1 still captures", int'(evt_flag[1]), 1);
    pin_in = 2'b00;
    tick(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule